// File: doc/BRIEF.md
# Register-Addressed Serial Slave Port

This block is a synchronous serial slave that gives an external host read and write access to a small bank of mixed-width configuration registers. Each communication cycle opens with an eight-bit instruction, sent most significant bit first. The instruction holds a direction flag and a register address. A data phase follows, and its length is exactly the byte width of the addressed register. When the last data bit has been clocked, the controller is ready for a new instruction. The host does not need to toggle chip select between cycles.

The serial pins (`sclk`, `cs_n`, `sdio_in`) are oversampled by the core clock through synchronisers. Both edges of the serial clock are then detected as single-cycle strobes, so all state runs in one clock domain with a synchronous active-high reset. Input bits are taken on rising serial-clock edges. Read bits are launched on falling edges. The serial clock may rest low or high between bursts.

Read data can leave in one of two ways. In three-wire mode it uses a dedicated `sdo` pin. In two-wire mode it is turned back onto the shared data line through `sdio_out` and `sdio_oe`. Every register is also presented in parallel to the core on `regs_flat`.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, every register in `regs_flat` is zero, and both `sdio_oe` and `sdo` are low.
- R2: The first eight rising `sclk` edges after chip select asserts shift in the instruction, MSB first. Bit 7 = 1 selects a read and 0 selects a write. Bits 4..0 give the address. Bits 6..5 have no effect.
- R3: The register widths are: address 0 is 4 bytes, 1 is 3 bytes, 2 is 1 byte, 3 is 2 bytes and 4 is 4 bytes. Register `a` occupies `regs_flat[32*a +: 32]`, zero-extended. The data phase moves exactly that many bytes, MSB first, and the first byte sent is the most significant.
- R4: After the final data bit, the next eight rising edges form a new instruction while chip select stays low.
- R5: A write changes the target register only once all of its bytes have arrived. A write cut short leaves the register unchanged.
- R6: Deasserting `cs_n` aborts any partial instruction or data phase. The next cycle starts again with a fresh instruction.
- R7: Read data changes on falling `sclk` edges. The MSB of the register is valid before the first rising edge of the data phase.
- R8: With `three_wire`=1, read data appears on `sdo` and `sdio_oe` stays low. Values on `sdio_in` during a read data phase change no register.
- R9: With `three_wire`=0, read data appears on `sdio_out`. `sdio_oe` is high during the read data phase and low once it ends. `sdo` stays low.
- R10: Addresses 5 to 31 act as 1-byte registers. Writes to them change nothing and reads from them return zero.
- R11: Transfers work the same whether `sclk` rests high or low between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| three_wire | input | 1 | 1: read data on `sdo`; 0: read data on the shared data line |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Input side of the shared data line |
| sdio_out | output | 1 | Read data toward the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo | output | 1 | Dedicated read data output |
| regs_flat | output | 160 | All registers side by side, 32 bits per register |

## Verification
Some rules are checked by the assertions on every cycle. The first is that `sdio_oe` never rises in three-wire mode and only rises while a data phase is active. The second is that the register bank changes only on a commit strobe, and never when the strobe targets an unmapped address. The third is that a released chip select returns the controller to the instruction phase. Other behaviour can only be shown by the bench's scenarios. These include the exact data-phase length per register, the MSB-first bit order in both directions, back-to-back cycles under one chip select, aborted writes leaving the old value in place, and identical results with the clock resting high or low.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    parameter int ADDR_W    = 5;
    parameter int NUM_REGS  = 5;
    parameter int MAX_BYTES = 4;

    localparam int WORD_W  = MAX_BYTES * 8;
    localparam int CNT_W   = $clog2(MAX_BYTES);
    localparam int INSTR_W = 8;

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    // index of the final byte of a transfer to address a
    function automatic logic [CNT_W-1:0] last_byte(input logic [ADDR_W-1:0] a);
        case (a)
            5'd0:    return CNT_W'(3);
            5'd1:    return CNT_W'(2);
            5'd2:    return CNT_W'(0);
            5'd3:    return CNT_W'(1);
            5'd4:    return CNT_W'(3);
            default: return CNT_W'(0);
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] byte_mask(input logic [ADDR_W-1:0] a);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int k = 0; k < MAX_BYTES; k++)
            if (k <= int'(last_byte(a))) m[k*8 +: 8] = 8'hFF;
        return m;
    endfunction

endpackage

// File: rtl/spi_pin_sampler.sv
module spi_pin_sampler
    import spi_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdio_in,
    output logic active,
    output logic rise,
    output logic fall,
    output logic sdio_s
);
    logic [SYNC_STAGES-1:0] sclk_sr, cs_sr, sd_sr;
    logic                   sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sr   <= '0;
            cs_sr     <= '1;
            sd_sr     <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_sr   <= {sclk_sr[SYNC_STAGES-2:0], sclk};
            cs_sr     <= {cs_sr[SYNC_STAGES-2:0], cs_n};
            sd_sr     <= {sd_sr[SYNC_STAGES-2:0], sdio_in};
            sclk_prev <= sclk_sr[SYNC_STAGES-1];
        end
    end

    assign active = !cs_sr[SYNC_STAGES-1];
    assign rise   = active &&  sclk_sr[SYNC_STAGES-1] && !sclk_prev;
    assign fall   = active && !sclk_sr[SYNC_STAGES-1] &&  sclk_prev;
    assign sdio_s = sd_sr[SYNC_STAGES-1];
endmodule

// File: rtl/spi_serial_engine.sv
module spi_serial_engine
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdio_s,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output phase_e            phase,
    output logic              is_read,
    output logic [ADDR_W-1:0] addr,
    output logic              commit,
    output logic [WORD_W-1:0] wr_data,
    output logic              tx_bit
);
    logic [INSTR_W-1:0] ins_q, ins_next;
    logic [2:0]         bit_cnt;
    logic [CNT_W-1:0]   byte_cnt;
    logic [WORD_W-1:0]  sh_q, rd_aligned;
    phase_e             phase_q;
    logic               tx_q;

    assign ins_next = {ins_q[INSTR_W-2:0], sdio_s};
    assign rd_addr  = ins_next[ADDR_W-1:0];
    // left-align the addressed register so its MSB sits at the top of the shifter
    assign rd_aligned = rd_data << ((MAX_BYTES - 1 - int'(last_byte(rd_addr))) * 8);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            phase_q  <= PH_INSTR;
            ins_q    <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            sh_q     <= '0;
            commit   <= 1'b0;
            tx_q     <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                if (phase_q == PH_INSTR) begin
                    ins_q <= ins_next;
                    if (bit_cnt == 3'd7) begin
                        phase_q  <= PH_DATA;
                        byte_cnt <= '0;
                        sh_q     <= ins_next[INSTR_W-1] ? rd_aligned : '0;
                    end
                end else begin
                    if (!ins_q[INSTR_W-1]) sh_q <= {sh_q[WORD_W-2:0], sdio_s};
                    if (bit_cnt == 3'd7) begin
                        if (byte_cnt == last_byte(ins_q[ADDR_W-1:0])) begin
                            phase_q <= PH_INSTR;
                            commit  <= !ins_q[INSTR_W-1];
                        end else begin
                            byte_cnt <= byte_cnt + CNT_W'(1);
                        end
                    end
                end
            end else if (fall && phase_q == PH_DATA && ins_q[INSTR_W-1]) begin
                tx_q <= sh_q[WORD_W-1];
                sh_q <= {sh_q[WORD_W-2:0], 1'b0};
            end
        end
    end

    assign phase   = phase_q;
    assign is_read = ins_q[INSTR_W-1];
    assign addr    = ins_q[ADDR_W-1:0];
    assign wr_data = sh_q;
    assign tx_bit  = tx_q;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_reg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       commit,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [WORD_W-1:0]          rd_data,
    output logic [NUM_REGS*WORD_W-1:0] regs_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (commit && wr_addr == ADDR_W'(i))
                q <= wr_data & byte_mask(ADDR_W'(i));
        end
        assign regs_flat[i*WORD_W +: WORD_W] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = regs_flat[i*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
    import spi_reg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       three_wire,
    input  logic                       sclk,
    input  logic                       cs_n,
    input  logic                       sdio_in,
    output logic                       sdio_out,
    output logic                       sdio_oe,
    output logic                       sdo,
    output logic [NUM_REGS*WORD_W-1:0] regs_flat
);
    logic              link_active, sclk_rise, sclk_fall, sdio_s;
    logic [WORD_W-1:0] rd_data, wr_data;
    logic [ADDR_W-1:0] rd_addr, eng_addr;
    phase_e            eng_phase;
    logic              eng_read, eng_commit, tx_bit;

    spi_pin_sampler #(.SYNC_STAGES(2)) u_pins (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
        .active(link_active), .rise(sclk_rise), .fall(sclk_fall), .sdio_s(sdio_s)
    );

    spi_serial_engine u_eng (
        .clk(clk), .rst(rst), .active(link_active), .rise(sclk_rise),
        .fall(sclk_fall), .sdio_s(sdio_s), .rd_data(rd_data), .rd_addr(rd_addr),
        .phase(eng_phase), .is_read(eng_read), .addr(eng_addr),
        .commit(eng_commit), .wr_data(wr_data), .tx_bit(tx_bit)
    );

    spi_reg_bank u_bank (
        .clk(clk), .rst(rst), .commit(eng_commit), .wr_addr(eng_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .regs_flat(regs_flat)
    );

    assign sdio_out = tx_bit;
    assign sdo      = three_wire & tx_bit;
    assign sdio_oe  = !three_wire && link_active && eng_phase == PH_DATA && eng_read;
endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk
    import spi_reg_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       three_wire,
    input logic                       sdio_oe,
    input logic [NUM_REGS*WORD_W-1:0] regs_flat,
    input logic                       active,
    input phase_e                     phase,
    input logic                       commit,
    input logic [ADDR_W-1:0]          wr_addr
);
    p_oe_off_three_wire_r8: assert property (@(posedge clk) disable iff (rst)
        three_wire |-> !sdio_oe);

    p_oe_in_data_r9: assert property (@(posedge clk) disable iff (rst)
        sdio_oe |-> (active && phase == PH_DATA));

    p_abort_to_instr_r6: assert property (@(posedge clk) disable iff (rst)
        !active |=> (phase == PH_INSTR && !commit));

    p_bank_holds_r5: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(regs_flat));

    p_unmapped_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (commit && int'(wr_addr) >= NUM_REGS) |=> $stable(regs_flat));
endmodule

bind spi_reg_port spi_reg_port_chk u_chk (
    .clk(clk), .rst(rst), .three_wire(three_wire), .sdio_oe(sdio_oe),
    .regs_flat(regs_flat), .active(link_active), .phase(eng_phase),
    .commit(eng_commit), .wr_addr(eng_addr)
);

// File: tb/spi_reg_port_test.sv
`timescale 1ns/1ps
module spi_reg_port_test;
    localparam int HALF_NS = 40;
    localparam int NV      = 8;
    localparam logic [39:0] VEC [NV] = '{
        {8'd0,  32'hDEADBEEF}, {8'd1,  32'h00A5C3E1}, {8'd2,  32'h0000007E},
        {8'd3,  32'h00001234}, {8'd4,  32'h89ABCDEF}, {8'd9,  32'h000000FF},
        {8'd31, 32'h00000055}, {8'd1,  32'h12FFFFFF}
    };

    logic clk = 0, rst = 1, three_wire = 1, sclk = 0, cs_n = 1, sdio_drv = 0;
    logic sdio_out, sdio_oe, sdo;
    logic [159:0] regs_flat;
    logic idle_hi = 0, samp_oe, samp_sdo, done = 0;
    int   errors = 0, checks = 0;

    spi_reg_port uut (
        .clk(clk), .rst(rst), .three_wire(three_wire), .sclk(sclk), .cs_n(cs_n),
        .sdio_in(sdio_drv), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo),
        .regs_flat(regs_flat)
    );

    always #2.5 clk = ~clk;

    function automatic int nbytes(input int a);
        case (a)
            0: return 4; 1: return 3; 2: return 1; 3: return 2; 4: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] reg_of(input int a);
        return regs_flat[a*32 +: 32];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bitx(input logic b, output logic r);
        if (sclk) begin sclk = 0; #HALF_NS; end
        sdio_drv = b;
        #HALF_NS;
        r = three_wire ? sdo : sdio_out;
        samp_oe  = sdio_oe;
        samp_sdo = sdo;
        sclk = 1;
        #HALF_NS;
        if (!idle_hi) begin sclk = 0; #HALF_NS; end
    endtask

    task automatic xbyte(input logic [7:0] v, output logic [7:0] r, output logic oe_all, output logic sdo_any);
        oe_all = 1; sdo_any = 0;
        for (int i = 7; i >= 0; i--) begin
            logic rb;
            bitx(v[i], rb);
            r[i] = rb;
            oe_all  &= samp_oe;
            sdo_any |= samp_sdo;
        end
    endtask

    task automatic cs_on();  cs_n = 0; #HALF_NS; endtask
    task automatic cs_off(); #HALF_NS; cs_n = 1; #(2*HALF_NS); endtask

    task automatic wr_body(input logic [7:0] ins, input logic [31:0] d, input int n);
        logic [7:0] r; logic o, s;
        xbyte(ins, r, o, s);
        for (int k = n - 1; k >= 0; k--) xbyte(d[k*8 +: 8], r, o, s);
    endtask

    task automatic rd_body(input int a, input logic [7:0] fill, output logic [31:0] v,
                           output logic oe_all, output logic sdo_any);
        logic [7:0] r; logic o, s;
        xbyte({1'b1, 2'b00, 5'(a)}, r, o, s);
        v = '0; oe_all = 1; sdo_any = 0;
        for (int k = 0; k < nbytes(a); k++) begin
            xbyte(fill, r, o, s);
            v = {v[23:0], r};
            oe_all &= o; sdo_any |= s;
        end
    endtask

    task automatic write_reg(input int a, input logic [31:0] d);
        cs_on(); wr_body({1'b0, 2'b00, 5'(a)}, d, nbytes(a)); cs_off();
    endtask

    task automatic read_reg(input int a, output logic [31:0] v);
        logic o, s;
        cs_on(); rd_body(a, 8'h00, v, o, s); cs_off();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, snap, exp;
        logic o, s;
        logic [7:0] r;
        repeat (10) @(posedge clk);
        rst = 0;
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        for (int a = 0; a < 5; a++) check("R1 reg zero", reg_of(a), 32'h0);
        check("R1 oe low", {31'b0, sdio_oe}, 32'h0);
        check("R1 sdo low", {31'b0, sdo}, 32'h0);

        // table walk: R3 widths, R7 read order, R10 unmapped
        for (int i = 0; i < NV; i++) begin
            int a;
            logic [31:0] mask;
            a = int'(VEC[i][39:32]);
            snap = reg_of(1) ^ reg_of(0) ^ reg_of(2) ^ reg_of(3) ^ reg_of(4);
            write_reg(a, VEC[i][31:0]);
            mask = (nbytes(a) == 4) ? 32'hFFFFFFFF : ((32'h1 << (8*nbytes(a))) - 1);
            exp  = (a < 5) ? (VEC[i][31:0] & mask) : 32'h0;
            read_reg(a, v);
            if (a < 5) begin
                check("R3 parallel value", reg_of(a), exp);
                check("R7 read back", v, exp);
            end else begin
                check("R10 unmapped read zero", v, 32'h0);
                check("R10 unmapped write ignored",
                      reg_of(1) ^ reg_of(0) ^ reg_of(2) ^ reg_of(3) ^ reg_of(4), snap);
            end
        end

        // R2: bits 6..5 ignored
        cs_on(); wr_body(8'h62, 32'h3C, 1); cs_off();
        check("R2 spare bits ignored", reg_of(2), 32'h3C);

        // R5/R6: write aborted after two of four bytes
        cs_on(); wr_body(8'h04, 32'h1122, 2); cs_off();
        check("R5 partial write no change", reg_of(4), 32'h89ABCDEF);
        // R6: abort in the middle of an instruction, then a normal write
        cs_on();
        bitx(1'b1, r[0]); bitx(1'b0, r[0]); bitx(1'b1, r[0]); bitx(1'b0, r[0]);
        cs_off();
        write_reg(3, 32'h5A5A);
        check("R6 restart after abort", reg_of(3), 32'h5A5A);
        check("R6 other regs intact", reg_of(4), 32'h89ABCDEF);

        // R4: three cycles under one chip select
        cs_on();
        wr_body(8'h02, 32'h99, 1);
        wr_body(8'h03, 32'h0FF0, 2);
        rd_body(2, 8'h00, v, o, s);
        cs_off();
        check("R4 back-to-back write a", reg_of(2), 32'h99);
        check("R4 back-to-back write b", reg_of(3), 32'h0FF0);
        check("R4 back-to-back read", v, 32'h99);

        // R11: clock resting high
        sclk = 1; idle_hi = 1; #(2*HALF_NS);
        write_reg(1, 32'h445566);
        read_reg(1, v);
        check("R11 stall high write", reg_of(1), 32'h445566);
        check("R11 stall high read", v, 32'h445566);
        idle_hi = 0; sclk = 0; #(2*HALF_NS);

        // R9: two-wire read
        three_wire = 0;
        cs_on();
        rd_body(0, 8'h00, v, o, s);
        #(2*HALF_NS);
        check("R9 two-wire data", v, 32'hDEADBEEF);
        check("R9 oe during data", {31'b0, o}, 32'h1);
        check("R9 sdo stays low", {31'b0, s}, 32'h0);
        check("R9 oe drops after data", {31'b0, sdio_oe}, 32'h0);
        cs_off();

        // R8: three-wire read with sdio toggling high
        three_wire = 1;
        cs_on();
        rd_body(3, 8'hFF, v, o, s);
        cs_off();
        check("R8 three-wire data", v, 32'h0FF0);
        check("R8 oe never high", {31'b0, o}, 32'h0);
        check("R8 sdio ignored in read", reg_of(3), 32'h0FF0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule